// File: doc/BRIEF.md
# Dithered Edge-Aligned PWM Generator

This block is an up-counting timer that drives an edge-aligned PWM reference. Each period the counter starts at zero and counts up to the reload value in use. The output is high while the count is below the compare value in use. A one-clock pulse marks the last count of every period, which is the point where the next period's settings are taken.

A single dither enable turns the low four bits of the compare and reload inputs into a fraction. The bits above them then form the integer part. Over each run of sixteen consecutive periods, a fixed spread pattern adds one clock to the integer compare value and to the integer reload value in some of those periods. The average duty cycle and the average period therefore resolve to 1/16 of a count. The pattern compares the bit-reversed period index against the fraction, so the stretched periods are spaced out and not bunched together. With dithering off, each input is used whole as an integer.

The run input gates all progress. While it is low the counter, the output level and the period index stay where they are.

Top module: `dpwm_gen`

## Requirements
- R1: During reset and in the first cycle with run high after reset, cnt is 0, pwm_ref is low and wrap_pulse is low. That first cycle loads the settings, and period index 0 starts on the next clock.
- R2: With run high, cnt rises by one per clock from 0 up to L, the reload value in use, and then returns to 0. Each period is therefore L+1 clocks long.
- R3: pwm_ref is high exactly while cnt is below C, the compare value in use, so a period's high-time is min(C, L+1) clocks.
- R4: If C is 0, pwm_ref stays low for the whole period. If C is greater than L, pwm_ref stays high for the whole period.
- R5: While run is low, cnt, pwm_ref and the period index hold their values, and wrap_pulse stays low.
- R6: wrap_pulse is high for one clock in the cycle where cnt equals L and run is high, and at no other time.
- R7: With dith_en low, C is cmp_val and L is rld_val, used whole. The low four bits get no special treatment.
- R8: With dith_en high, each input splits into an integer I (bits 15:4) and a fraction f (bits 3:0). The value in use is I+1 when the bit-reversed period index is less than f, and I otherwise. The period index k counts 0 to 15, is 0 after reset, and advances at each wrap. The bit reversal swaps bit 0 with bit 3 and bit 1 with bit 2.
- R9: With dithering on and fixed settings, the 16 periods k=0..15 together last 16(Ir+1)+fr clocks. When Ic+(fc≠0) ≤ Ir+1, they are high for 16·Ic+fc clocks in total.
- R10: cmp_val, rld_val and dith_en are sampled only in the load cycle and in the cycles where wrap_pulse is high. A change at any other point leaves the current period untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low freezes the timer |
| dith_en | input | 1 | Selects fractional dithering of both settings |
| cmp_val | input | CNT_W | Duty-cycle compare setting |
| rld_val | input | CNT_W | Period reload setting |
| cnt | output | CNT_W | Current counter value |
| pwm_ref | output | 1 | PWM reference output |
| wrap_pulse | output | 1 | One-clock marker on the last count of each period |

## Verification
The hardest case to reach is a settings change that lands in the middle of a period while the timer is also paused at random points. An error here would only show as a single period with the wrong shape inside a sixteen-period dither sequence. The stimulus changes the compare and reload inputs at random clocks and drops run at random clocks, in both dithered and plain modes. The bench keeps its own record of which settings were sampled at each wrap and which period index applies, and it checks the output level on every clock against that record. Directed runs cover a zero compare, a compare above the reload, a reload of zero, fractions that push the compare past the reload, and full sixteen-period windows for the average checks.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   // Reason the active settings are captured in a given cycle
   typedef enum logic [1:0] {
      LATCH_NONE = 2'd0,
      LATCH_LOAD = 2'd1,
      LATCH_WRAP = 2'd2
   } latch_e;

   localparam int unsigned DPWM_MAX_CNT_W  = 32;
   localparam int unsigned DPWM_MAX_FRAC_W = 8;

endpackage

// File: rtl/dpwm_phase_seq.sv
// Period index of the dither sequence; gives the bit-reversed index that the
// period about to be latched will use.
module dpwm_phase_seq #(
   parameter int unsigned PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            live,
   input  logic            wrap,
   output logic [PH_W-1:0] ph_rev_next
);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (wrap) begin
         ph_q <= ph_q + PH_W'(1);
      end
   end

   // Load cycle keeps index 0; a wrap moves to the following index
   always_comb begin
      ph_next = live ? (ph_q + PH_W'(1)) : ph_q;
   end

   for (genvar b = 0; b < PH_W; b++) begin : g_rev
      assign ph_rev_next[b] = ph_next[PH_W-1-b];
   end

endmodule

// File: rtl/dpwm_dither_sel.sv
// Turns a raw setting into the integer value used for one period.
module dpwm_dither_sel #(
   parameter int unsigned VAL_W       = 16,
   parameter int unsigned FRAC_W      = 4,
   parameter bit          DITHER_IMPL = 1'b1
) (
   input  logic              dith_en,
   input  logic [VAL_W-1:0]  raw,
   input  logic [FRAC_W-1:0] ph_rev,
   output logic [VAL_W-1:0]  eff
);

   localparam int unsigned WHOLE_W = VAL_W - FRAC_W;

   if (DITHER_IMPL) begin : g_dith
      logic [FRAC_W-1:0]  frac;
      logic [WHOLE_W-1:0] whole;
      logic               stretch;

      always_comb begin
         frac    = raw[FRAC_W-1:0];
         whole   = raw[VAL_W-1:FRAC_W];
         stretch = dith_en && (ph_rev < frac);
         if (dith_en) begin
            eff = {{FRAC_W{1'b0}}, whole} + {{(VAL_W-1){1'b0}}, stretch};
         end else begin
            eff = raw;
         end
      end
   end else begin : g_plain
      logic unused_dith;
      assign unused_dith = ^{dith_en, ph_rev};
      assign eff         = raw;
   end

endmodule

// File: rtl/dpwm_timebase.sv
// Edge-aligned up counter with the per-period active settings.
module dpwm_timebase
   import dpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] nxt_cmp,
   input  logic [CNT_W-1:0] nxt_rld,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_cmp,
   output logic [CNT_W-1:0] act_rld,
   output logic             live,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] rld_q;
   logic             live_q;
   latch_e           cause;

   always_comb begin
      cause = LATCH_NONE;
      if (run) begin
         if (!live_q) begin
            cause = LATCH_LOAD;
         end else if (cnt_q == rld_q) begin
            cause = LATCH_WRAP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cmp_q  <= '0;
         rld_q  <= '0;
         live_q <= 1'b0;
      end else begin
         if (cause != LATCH_NONE) begin
            cmp_q <= nxt_cmp;
            rld_q <= nxt_rld;
         end
         case (cause)
            LATCH_LOAD: live_q <= 1'b1;
            LATCH_WRAP: cnt_q  <= '0;
            default: begin
               if (run && live_q) begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign cnt     = cnt_q;
   assign act_cmp = cmp_q;
   assign act_rld = rld_q;
   assign live    = live_q;
   assign wrap    = (cause == LATCH_WRAP);

endmodule

// File: rtl/dpwm_outcmp.sv
// Output stage for the first PWM mode: high while the count is below the compare value.
module dpwm_outcmp #(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] act_cmp,
   output logic             pwm
);

   always_comb begin
      pwm = (cnt < act_cmp);
   end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
   import dpwm_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FRAC_W     = 4,
   parameter bit          HAS_DITHER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             dith_en,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] rld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             pwm_ref,
   output logic             wrap_pulse
);

   if (FRAC_W < 1 || FRAC_W > DPWM_MAX_FRAC_W) begin : g_bad_frac
      $error("dpwm_gen: FRAC_W out of range");
   end
   if (CNT_W < FRAC_W + 2 || CNT_W > DPWM_MAX_CNT_W) begin : g_bad_cnt
      $error("dpwm_gen: CNT_W out of range for FRAC_W");
   end

   logic [FRAC_W-1:0] ph_rev_next;
   logic [CNT_W-1:0]  nxt_cmp;
   logic [CNT_W-1:0]  nxt_rld;
   logic [CNT_W-1:0]  act_cmp;
   logic [CNT_W-1:0]  act_rld;
   logic              live;
   logic              wrap;

   dpwm_phase_seq #(.PH_W(FRAC_W)) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .live        (live),
      .wrap        (wrap),
      .ph_rev_next (ph_rev_next)
   );

   dpwm_dither_sel #(.VAL_W(CNT_W), .FRAC_W(FRAC_W), .DITHER_IMPL(HAS_DITHER)) u_sel_cmp (
      .dith_en (dith_en),
      .raw     (cmp_val),
      .ph_rev  (ph_rev_next),
      .eff     (nxt_cmp)
   );

   dpwm_dither_sel #(.VAL_W(CNT_W), .FRAC_W(FRAC_W), .DITHER_IMPL(HAS_DITHER)) u_sel_rld (
      .dith_en (dith_en),
      .raw     (rld_val),
      .ph_rev  (ph_rev_next),
      .eff     (nxt_rld)
   );

   dpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .nxt_cmp (nxt_cmp),
      .nxt_rld (nxt_rld),
      .cnt     (cnt),
      .act_cmp (act_cmp),
      .act_rld (act_rld),
      .live    (live),
      .wrap    (wrap)
   );

   dpwm_outcmp #(.CNT_W(CNT_W)) u_out (
      .cnt     (cnt),
      .act_cmp (act_cmp),
      .pwm     (pwm_ref)
   );

   assign wrap_pulse = wrap;

endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic             pwm_ref,
   input logic             wrap_pulse,
   input logic             live,
   input logic [CNT_W-1:0] act_cmp,
   input logic [CNT_W-1:0] act_rld
);

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !live |-> (!wrap_pulse && cnt == '0)); // R1
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) live |-> (cnt <= act_rld)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && live && !wrap_pulse) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap_pulse |=> (cnt == '0)); // R2
   AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (act_cmp == '0) |-> !pwm_ref); // R4
   AST_OVER_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (live && act_cmp > act_rld) |-> pwm_ref); // R4
   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> ($stable(cnt) && $stable(act_cmp) && $stable(act_rld))); // R5
   AST_PAUSE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !wrap_pulse); // R5
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wrap_pulse |=> (!wrap_pulse || act_rld == '0)); // R6
   AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (live && !wrap_pulse) |=> ($stable(act_cmp) && $stable(act_rld))); // R10

endmodule

bind dpwm_gen dpwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .cnt        (cnt),
   .pwm_ref    (pwm_ref),
   .wrap_pulse (wrap_pulse),
   .live       (live),
   .act_cmp    (act_cmp),
   .act_rld    (act_rld)
);

// File: tb/tb_dpwm_gen.sv
module tb_dpwm_gen;
   localparam int CNT_W = 16;

   logic             clk     = 1'b0;
   logic             rst_n   = 1'b0;
   logic             run     = 1'b0;
   logic             dith_en = 1'b0;
   logic [CNT_W-1:0] cmp_val = '0;
   logic [CNT_W-1:0] rld_val = '0;
   logic [CNT_W-1:0] cnt;
   logic             pwm_ref;
   logic             wrap_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Model of the period in progress
   int pos, per_high, idx, exp_c, exp_l, sum_len, sum_high, win_per, per_done;
   bit exp_d, win_clean;

   always #5 clk = ~clk;

   dpwm_gen #(.CNT_W(CNT_W), .FRAC_W(4), .HAS_DITHER(1'b1)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .dith_en    (dith_en),
      .cmp_val    (cmp_val),
      .rld_val    (rld_val),
      .cnt        (cnt),
      .pwm_ref    (pwm_ref),
      .wrap_pulse (wrap_pulse)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int bitrev4(int k);
      return int'({k[0], k[1], k[2], k[3]});
   endfunction

   function automatic int eff(int raw, bit d, int k);
      if (!d) return raw;
      return (raw >> 4) + ((bitrev4(k) < (raw & 15)) ? 1 : 0);
   endfunction

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic latch_model();
      exp_c = eff(int'(cmp_val), dith_en, idx);
      exp_l = eff(int'(rld_val), dith_en, idx);
      exp_d = dith_en;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic start_run(int c, int l, bit d);
      @(negedge clk);
      rst_n = 1'b0; run = 1'b0;
      cmp_val = CNT_W'(c); rld_val = CNT_W'(l); dith_en = d;
      #1;
      check(int'(cnt) == 0, "R1 count in reset", int'(cnt), 0);
      check(!pwm_ref, "R1 output in reset", int'(pwm_ref), 0);
      @(negedge clk);
      rst_n = 1'b1; run = 1'b1;
      #1;
      check(int'(cnt) == 0, "R1 count in load cycle", int'(cnt), 0);
      check(!pwm_ref, "R1 output in load cycle", int'(pwm_ref), 0);
      check(!wrap_pulse, "R1 pulse in load cycle", int'(wrap_pulse), 0);
      idx = 0; latch_model();
      pos = 0; per_high = 0; sum_len = 0; sum_high = 0; win_per = 0; win_clean = 1'b1;
   endtask

   task automatic window_end();
      int ir, fr, ic, fc;
      ir = exp_d ? (int'(rld_val) >> 4) : int'(rld_val);
      fr = exp_d ? (int'(rld_val) & 15) : 0;
      ic = exp_d ? (int'(cmp_val) >> 4) : int'(cmp_val);
      fc = exp_d ? (int'(cmp_val) & 15) : 0;
      check(sum_len == 16 * (ir + 1) + fr, "R9 total length of 16 periods", sum_len, 16 * (ir + 1) + fr);
      if (ic + ((fc != 0) ? 1 : 0) <= ir + 1)
         check(sum_high == 16 * ic + fc, "R9 total high-time of 16 periods", sum_high, 16 * ic + fc);
   endtask

   task automatic step(bit r, int c, int l, bit d);
      @(negedge clk);
      if (CNT_W'(c) != cmp_val || CNT_W'(l) != rld_val || d != dith_en) win_clean = 1'b0;
      run = r; cmp_val = CNT_W'(c); rld_val = CNT_W'(l); dith_en = d;
      #1;
      if (run) begin
         check(int'(cnt) == pos, "R2 count value", int'(cnt), pos);
         check(pwm_ref == (pos < exp_c), "R3 R10 output level", int'(pwm_ref), int'(pos < exp_c));
         per_high += int'(pwm_ref);
         pos++;
         check(wrap_pulse == (pos == exp_l + 1), "R6 wrap pulse", int'(wrap_pulse), int'(pos == exp_l + 1));
         if (pos == exp_l + 1) begin
            check(wrap_pulse, exp_d ? "R8 dithered period length" : "R7 plain period length",
                  int'(wrap_pulse), 1);
            check(per_high == imin(exp_c, exp_l + 1), exp_d ? "R8 dithered high-time" : "R7 plain high-time",
                  per_high, imin(exp_c, exp_l + 1));
            if (exp_c == 0) check(per_high == 0, "R4 zero compare", per_high, 0);
            if (exp_c > exp_l) check(per_high == pos, "R4 compare above reload", per_high, pos);
            sum_len += pos; sum_high += per_high; win_per++; per_done++;
            if (win_per == 16) begin
               if (win_clean && exp_d == dith_en) window_end();
               win_per = 0; sum_len = 0; sum_high = 0; win_clean = 1'b1;
            end
            idx = (idx + 1) % 16;
            latch_model();
            pos = 0; per_high = 0;
         end
      end else begin
         check(int'(cnt) == pos, "R5 count frozen", int'(cnt), pos);
         check(!wrap_pulse, "R5 no pulse while paused", int'(wrap_pulse), 0);
         check(pwm_ref == (pos < exp_c), "R5 level held", int'(pwm_ref), int'(pos < exp_c));
      end
   endtask

   function automatic int rand_rld(bit d);
      return d ? int'($urandom_range(640, 0)) : int'($urandom_range(40, 0));
   endfunction

   function automatic int rand_cmp(int l, bit d);
      return d ? int'($urandom_range(l + 48, 0)) : int'($urandom_range(l + 3, 0));
   endfunction

   task automatic run_periods(int n, int pause_pct, int chg_pct);
      int target;
      int c, l;
      bit d;
      target = per_done + n;
      c = int'(cmp_val); l = int'(rld_val); d = dith_en;
      while (per_done < target) begin
         bit r;
         r = (int'($urandom_range(99, 0)) >= pause_pct);
         if (int'($urandom_range(99, 0)) < chg_pct) begin
            l = rand_rld(d);
            c = rand_cmp(l, d);
         end
         step(r, c, l, d);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      per_done = 0;
      // Plain mode, reload 8: period of 9 clocks
      start_run(4, 8, 1'b0);        run_periods(16, 0, 0);   // R7 R9
      start_run(9, 8, 1'b0);        run_periods(3, 0, 0);    // R4 held high
      start_run(8, 8, 1'b0);        run_periods(3, 0, 0);    // R3 one low clock
      start_run(0, 8, 1'b0);        run_periods(3, 0, 0);    // R4 held low
      start_run(1, 0, 1'b0);        run_periods(6, 0, 0);    // R2 one-clock period
      start_run(0, 0, 1'b0);        run_periods(4, 0, 0);
      start_run(40, 133, 1'b0);     run_periods(2, 0, 0);    // R7 fraction bits used whole
      // Dithered
      start_run(4*16+3, 8*16+5, 1'b1);  run_periods(32, 0, 0);  // R8 R9
      start_run(3, 6*16+9, 1'b1);       run_periods(16, 0, 0);  // fractional compare near zero
      start_run(9*16+15, 9*16, 1'b1);   run_periods(16, 0, 0);  // compare stretched past reload
      start_run(15, 0, 1'b1);           run_periods(16, 0, 0);
      start_run(5*16+7, 12*16+2, 1'b1); run_periods(16, 25, 0); // R5 pauses
      start_run(2*16+9, 7*16+11, 1'b1); run_periods(24, 0, 6);  // R10 mid-period changes
      for (int s = 0; s < 24; s++) begin
         bit d;
         int l;
         d = s[0];
         l = rand_rld(d);
         start_run(rand_cmp(l, d), l, d);
         run_periods(20, (s % 3 == 0) ? 10 : 0, (s % 4 == 1) ? 3 : 0);
      end
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule